// File: doc/BRIEF.md
# Byte-Wide Host Handshake Port with Ready Enables

This block sits between an 8-bit legacy host and a local controller. The host sees a small strobe-driven port. It holds `host_rd` or `host_wr` high until the access completes, and `host_cmd` picks the target: the status/command side or the data side. Two active-low enables announce work to the host. `stat_en_n` means queued status bytes are waiting, and `data_en_n` means a data byte can move now. `eot_n` marks the access that moves the final byte of a transfer. A single shared output, `wait_drq`, changes meaning with `host_pio`. In PIO mode it is a wait line that goes low to stretch an access that cannot complete yet. In DMA mode it is a DMA request.

The local side has three streams, each with a valid/ready pair. Status bytes come in through one stream. Bytes for the host come in through a second stream (`rd_*`). Bytes written by the host leave through a third stream (`wd_*`). Each stream moves a byte only in a cycle where both valid and ready are high. The producer must hold its byte stable until that happens. A local load pulse sets the byte count and the direction of a transfer. A command byte written by the host is handed to the local side as a one-cycle strobe. Only the low eight host data lanes carry information.

Top module: `hs8_host_port`

## Requirements
- R1: After reset: `stat_en_n`, `data_en_n` and `eot_n` are 1, the count is 0, `cmd_stb` and `wd_valid` are 0, `st_ready` is 1, `rd_ready` is 0, and in PIO mode with no access `wait_drq` is 1.
- R2: `stat_en_n` is 0 exactly while at least one status byte is queued. A status read (`host_rd`=1, `host_cmd`=1) presents the oldest queued byte on `host_rdata[7:0]` and removes it when it completes. Bytes come out in the order they were queued.
- R3: `st_ready` is 0 while SDEPTH status bytes are queued. A byte offered while `st_ready` is 0 is not taken.
- R4: A load pulse with `cnt_dir`=0 (to host) sets the count. `rd_ready` is 1 only when the count is nonzero, the holding byte is empty and no load is in progress. In this direction `data_en_n` is 0 exactly while a byte is held and the count is nonzero.
- R5: With `cnt_dir`=1 (from host), `data_en_n` is 0 exactly while the count is nonzero and the staging byte is empty. A completed data write stages `host_wdata[7:0]`, which is offered on `wd_data` with `wd_valid`=1 until `wd_ready` takes it.
- R6: Each completed data access lowers the count by one. Once the count is 0, `data_en_n` stays 1 and further data accesses do not complete.
- R7: `eot_n` is 0 only during a data access that completes while the count is 1. It is 1 at all other times.
- R8: In PIO mode (`host_pio`=1), `wait_drq` is 0 while a strobe is held for an access that cannot complete in this cycle, and 1 otherwise. An access cannot complete when it is a status read with nothing queued, or a data access the current direction, count or byte state does not allow.
- R9: In DMA mode (`host_pio`=0), `wait_drq` is 1 exactly when a data byte can move in the loaded direction, that is, equal to the inverse of `data_en_n`.
- R10: `host_rdata[15:8]` is always 0. `host_wdata[15:8]` has no effect on `cmd_byte` or `wd_data`.
- R11: A command write (`host_wr`=1, `host_cmd`=1) always completes. In the next cycle it gives `cmd_stb`=1 for one cycle with `cmd_byte` equal to `host_wdata[7:0]`. It does not change the status queue or the count.
- R12: A load pulse replaces the count and direction and discards any unread to-host byte. A load takes priority over a data access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe, held until complete |
| host_wr | input | 1 | Host write strobe, held until complete |
| host_cmd | input | 1 | 1 = status/command side, 0 = data side |
| host_pio | input | 1 | 1 = PIO (wait line), 0 = DMA (request line) |
| host_wdata | input | 16 | Host write data, low byte used |
| host_rdata | output | 16 | Host read data, high byte zero |
| stat_en_n | output | 1 | Low while status bytes are queued |
| data_en_n | output | 1 | Low while a data byte can move |
| eot_n | output | 1 | Low during the access moving the last byte |
| wait_drq | output | 1 | Wait (PIO) or DMA request (DMA) |
| cmd_stb | output | 1 | One-cycle command byte strobe |
| cmd_byte | output | 8 | Command byte from the host |
| st_valid | input | 1 | Status byte offered |
| st_ready | output | 1 | Status queue can accept |
| st_data | input | 8 | Status byte |
| cnt_load | input | 1 | Load count and direction |
| cnt_dir | input | 1 | 0 = to host, 1 = from host |
| cnt_value | input | CW | Byte count to load |
| rd_valid | input | 1 | To-host byte offered |
| rd_ready | output | 1 | To-host holding byte empty |
| rd_data | input | 8 | To-host byte |
| wd_valid | output | 1 | From-host byte waiting |
| wd_ready | input | 1 | Local side takes the byte |
| wd_data | output | 8 | From-host byte |

## Verification
A wrong count shows up on `eot_n`. If the count is too high, the enable stays low after the expected last byte. If it is too low, the strobe arrives on an earlier access. Both are visible in the same cycle as that access. A lost or duplicated holding byte appears as a wrong `data_en_n` or `rd_ready` level in the very next cycle, and as a wrong value on `host_rdata` at the following read. Status queue pointer faults show up as out-of-order or repeated status bytes, or as `stat_en_n` and `st_ready` at the wrong fill levels. A swapped meaning on the shared pin is seen at once when `host_pio` changes.

// File: rtl/hs8_pkg.sv
package hs8_pkg;
  localparam int BYTE_W = 8;
  localparam int HOST_W = 16;

  typedef enum logic {
    DIR_TO_HOST   = 1'b0,
    DIR_FROM_HOST = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/hs8_stat_fifo.sv
module hs8_stat_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = AW + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [LVL_W-1:0] level;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push_ready = (level != LVL_W'(DEPTH));
  assign nonempty   = (level != '0);
  assign do_push    = push_valid & push_ready;
  assign do_pop     = pop & nonempty;
  assign head       = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/hs8_xfer_count.sv
module hs8_xfer_count
  import hs8_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] value,
  input  xfer_dir_e     dir_in,
  input  logic          dec,
  output xfer_dir_e     dir,
  output logic          nonzero,
  output logic          is_one
);
  logic [CW-1:0] count;

  assign nonzero = (count != '0);
  assign is_one  = (count == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      dir   <= DIR_TO_HOST;
    end else if (load) begin
      count <= value;
      dir   <= dir_in;
    end else if (dec && nonzero) begin
      count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/hs8_data_stage.sv
module hs8_data_stage
  import hs8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  xfer_dir_e         dir,
  input  logic              cnt_nz,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              host_take,
  output logic              rd_full,
  output logic [BYTE_W-1:0] rd_byte,
  input  logic              host_put,
  input  logic [BYTE_W-1:0] put_byte,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [BYTE_W-1:0] wd_data
);
  logic wr_full;

  assign rd_ready = ~rd_full & cnt_nz & (dir == DIR_TO_HOST) & ~flush;
  assign wd_valid = wr_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_full <= 1'b0;
      rd_byte <= '0;
    end else if (flush || host_take) begin
      rd_full <= 1'b0;
    end else if (rd_valid && rd_ready) begin
      rd_full <= 1'b1;
      rd_byte <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_full <= 1'b0;
      wd_data <= '0;
    end else if (host_put) begin
      wr_full <= 1'b1;
      wd_data <= put_byte;
    end else if (wr_full && wd_ready) begin
      wr_full <= 1'b0;
    end
  end
endmodule

// File: rtl/hs8_host_port.sv
module hs8_host_port
  import hs8_pkg::*;
#(
  parameter int CW    = 16,
  parameter int SDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_cmd,
  input  logic          host_pio,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          stat_en_n,
  output logic          data_en_n,
  output logic          eot_n,
  output logic          wait_drq,
  output logic          cmd_stb,
  output logic [7:0]    cmd_byte,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [7:0]    st_data,
  input  logic          cnt_load,
  input  logic          cnt_dir,
  input  logic [CW-1:0] cnt_value,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [7:0]    rd_data,
  output logic          wd_valid,
  input  logic          wd_ready,
  output logic [7:0]    wd_data
);
  xfer_dir_e         dir;
  logic              cnt_nz, cnt_one;
  logic              rd_full;
  logic [BYTE_W-1:0] rd_byte, st_head;
  logic              st_nonempty;
  logic              stat_rd_ok, data_rd_ok, data_wr_ok, cmd_wr_ok;
  logic              any_ok, pending, byte_can_move, data_done;
  logic              unused_hi;

  assign unused_hi = ^host_wdata[HOST_W-1:BYTE_W];

  assign byte_can_move = cnt_nz & ((dir == DIR_TO_HOST) ? rd_full : ~wd_valid);
  assign stat_rd_ok = host_rd & host_cmd & st_nonempty;
  assign cmd_wr_ok  = host_wr & host_cmd;
  assign data_rd_ok = host_rd & ~host_cmd & (dir == DIR_TO_HOST) & byte_can_move & ~cnt_load;
  assign data_wr_ok = host_wr & ~host_cmd & (dir == DIR_FROM_HOST) & byte_can_move & ~cnt_load;
  assign data_done  = data_rd_ok | data_wr_ok;
  assign any_ok     = stat_rd_ok | cmd_wr_ok | data_done;
  assign pending    = host_rd | host_wr;

  assign stat_en_n  = ~st_nonempty;
  assign data_en_n  = ~byte_can_move;
  assign eot_n      = ~(data_done & cnt_one);
  assign wait_drq   = host_pio ? ~(pending & ~any_ok) : byte_can_move;
  assign host_rdata = {{(HOST_W-BYTE_W){1'b0}}, host_cmd ? st_head : rd_byte};

  hs8_stat_fifo #(.DEPTH(SDEPTH), .W(BYTE_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (st_valid),
    .push_ready (st_ready),
    .push_data  (st_data),
    .pop        (stat_rd_ok),
    .head       (st_head),
    .nonempty   (st_nonempty)
  );

  hs8_xfer_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .value   (cnt_value),
    .dir_in  (xfer_dir_e'(cnt_dir)),
    .dec     (data_done),
    .dir     (dir),
    .nonzero (cnt_nz),
    .is_one  (cnt_one)
  );

  hs8_data_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cnt_load),
    .dir       (dir),
    .cnt_nz    (cnt_nz),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .host_take (data_rd_ok),
    .rd_full   (rd_full),
    .rd_byte   (rd_byte),
    .host_put  (data_wr_ok),
    .put_byte  (host_wdata[BYTE_W-1:0]),
    .wd_valid  (wd_valid),
    .wd_ready  (wd_ready),
    .wd_data   (wd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_stb  <= 1'b0;
      cmd_byte <= '0;
    end else begin
      cmd_stb <= cmd_wr_ok;
      if (cmd_wr_ok) cmd_byte <= host_wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/hs8_host_port_chk.sv
module hs8_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_rd,
  input logic        host_wr,
  input logic        host_cmd,
  input logic        host_pio,
  input logic [7:0]  wlo,
  input logic [15:0] host_rdata,
  input logic        stat_en_n,
  input logic        data_en_n,
  input logic        eot_n,
  input logic        wait_drq,
  input logic        cmd_stb,
  input logic [7:0]  cmd_byte,
  input logic        st_valid,
  input logic        st_ready,
  input logic        rd_ready,
  input logic        wd_valid,
  input logic        wd_ready,
  input logic [7:0]  wd_data
);
  AST_EOT_ON_DATA_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !eot_n |-> ((host_rd || host_wr) && !host_cmd && !data_en_n)); // R7
  AST_STAT_EN_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> !stat_en_n); // R2
  AST_FULL_MEANS_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> !stat_en_n); // R3
  AST_RD_READY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> data_en_n); // R4
  AST_WD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data))); // R5
  AST_PIO_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pio && !host_rd && !host_wr) |-> wait_drq); // R8
  AST_DMA_REQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !host_pio |-> (wait_drq == !data_en_n)); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[15:8] == 8'h00); // R10
  AST_CMD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_cmd) |=> (cmd_stb && cmd_byte == $past(wlo))); // R11
endmodule

bind hs8_host_port hs8_host_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_cmd   (host_cmd),
  .host_pio   (host_pio),
  .wlo        (host_wdata[7:0]),
  .host_rdata (host_rdata),
  .stat_en_n  (stat_en_n),
  .data_en_n  (data_en_n),
  .eot_n      (eot_n),
  .wait_drq   (wait_drq),
  .cmd_stb    (cmd_stb),
  .cmd_byte   (cmd_byte),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .rd_ready   (rd_ready),
  .wd_valid   (wd_valid),
  .wd_ready   (wd_ready),
  .wd_data    (wd_data)
);

// File: tb/test_hs8_host_port.sv
`timescale 1ns/1ps
module test_hs8_host_port;
  localparam int CW = 16;
  localparam int SDEPTH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, host_rd, host_wr, host_cmd, host_pio;
  logic [15:0] host_wdata, host_rdata;
  logic stat_en_n, data_en_n, eot_n, wait_drq, cmd_stb;
  logic [7:0] cmd_byte, st_data, rd_data, wd_data;
  logic st_valid, st_ready, cnt_load, cnt_dir, rd_valid, rd_ready, wd_valid, wd_ready;
  logic [CW-1:0] cnt_value;

  int checks = 0;
  int fails = 0;
  logic [7:0] bytes [0:31];

  hs8_host_port #(.CW(CW), .SDEPTH(SDEPTH)) i_hs8_host_port (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_eot_n(input int done, input int total);
    return !(done == total - 1);
  endfunction

  task automatic quiet();
    host_rd = 0; host_wr = 0; host_cmd = 0; st_valid = 0;
    cnt_load = 0; rd_valid = 0; wd_ready = 0;
  endtask

  task automatic load(input int n, input bit d);
    @(negedge clk); quiet(); cnt_load = 1; cnt_dir = d; cnt_value = CW'(n);
    @(negedge clk); cnt_load = 0;
  endtask

  initial begin
    #(4 * 100000);
    check(0, "WATCHDOG", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1d5e_0a7b));
    rst_n = 0; host_pio = 1; host_wdata = '0; st_data = '0; rd_data = '0;
    cnt_dir = 0; cnt_value = '0; quiet();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    check(stat_en_n && data_en_n && eot_n, "R1", {stat_en_n, data_en_n, eot_n}, 3'b111);
    check(!cmd_stb && !wd_valid && st_ready && !rd_ready && wait_drq, "R1",
          {cmd_stb, wd_valid, st_ready, rd_ready, wait_drq}, 5'b00101);
    rst_n = 1;

    // R2 / R3 status queue fill and drain
    for (int i = 0; i <= SDEPTH; i++) begin
      @(negedge clk); st_valid = 1; st_data = 8'(i * 37 + 5); bytes[i] = st_data; #1;
      check(st_ready == (i < SDEPTH), "R3", st_ready, i < SDEPTH);
    end
    @(negedge clk); st_valid = 0; #1;
    check(!stat_en_n, "R2", stat_en_n, 0);
    for (int i = 0; i < SDEPTH; i++) begin
      @(negedge clk); host_rd = 1; host_cmd = 1; #1;
      check(host_rdata == {8'h00, bytes[i]}, "R2", host_rdata, bytes[i]);
      check(wait_drq, "R8", wait_drq, 1);
    end
    @(negedge clk); #1;
    // queue now empty, strobe still held: cannot complete
    check(stat_en_n, "R2", stat_en_n, 1);
    check(!wait_drq, "R8", wait_drq, 0);

    // R11 command write, R10 upper lane ignored
    @(negedge clk); host_rd = 0; host_wr = 1; host_cmd = 1; host_wdata = 16'hA55A;
    @(negedge clk); host_wr = 0; #1;
    check(cmd_stb && cmd_byte == 8'h5A, "R11", {cmd_stb, cmd_byte}, 9'h15A);
    check(stat_en_n && data_en_n, "R11", {stat_en_n, data_en_n}, 2'b11);
    @(negedge clk); #1;
    check(!cmd_stb, "R11", cmd_stb, 0);

    // R4 / R6 / R7 / R8 to-host transfer, PIO
    n = $urandom_range(6, 20);
    for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
    load(n, 0);
    host_rd = 1; host_cmd = 0; #1;
    check(!wait_drq && data_en_n, "R8", {wait_drq, data_en_n}, 2'b01);
    begin
      int sent = 0, got = 0;
      bit full = 0, rdy;
      while (got < n) begin
        @(negedge clk);
        rd_valid = (sent < n) && ($urandom_range(0, 1) == 1);
        rd_data = bytes[sent < n ? sent : 0];
        host_rd = full && ($urandom_range(0, 2) != 0); host_cmd = 0;
        #1;
        rdy = rd_ready;
        check(data_en_n == !full, "R4", data_en_n, !full);
        check(rd_ready == !full, "R4", rd_ready, !full);
        if (host_rd) begin
          check(host_rdata == {8'h00, bytes[got]}, "R4", host_rdata, bytes[got]);
          check(eot_n == exp_eot_n(got, n), "R7", eot_n, exp_eot_n(got, n));
        end else check(eot_n, "R7", eot_n, 1);
        @(posedge clk);
        if (host_rd) begin got++; full = 0; end
        else if (rd_valid && rdy) begin sent++; full = 1; end
      end
    end
    @(negedge clk); quiet(); #1;
    check(data_en_n && !rd_ready, "R6", {data_en_n, rd_ready}, 2'b10);
    host_rd = 1; #1;
    check(!wait_drq && eot_n, "R6", {wait_drq, eot_n}, 2'b01);

    // R5 / R9 / R10 from-host transfer, DMA
    host_pio = 0;
    n = $urandom_range(6, 20);
    for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
    load(n, 1);
    begin
      int put = 0, took = 0;
      bit stg = 0, drq;
      logic [7:0] stgb = 0;
      while (took < n) begin
        @(negedge clk);
        drq = (put < n) && !stg;
        host_wr = drq && ($urandom_range(0, 1) == 1); host_cmd = 0;
        host_wdata = {8'($urandom), bytes[put < n ? put : 0]};
        wd_ready = ($urandom_range(0, 1) == 1);
        #1;
        check(wait_drq == drq, "R9", wait_drq, drq);
        check(data_en_n == !drq, "R5", data_en_n, !drq);
        check(wd_valid == stg, "R5", wd_valid, stg);
        if (stg) check(wd_data == stgb, "R10", wd_data, stgb);
        if (host_wr) check(eot_n == exp_eot_n(put, n), "R7", eot_n, exp_eot_n(put, n));
        @(posedge clk);
        if (stg && wd_ready) begin took++; stg = 0; end
        if (host_wr) begin stg = 1; stgb = bytes[put]; put++; end
      end
    end
    @(negedge clk); quiet(); #1;
    check(data_en_n && !wait_drq && !wd_valid, "R6", {data_en_n, wait_drq, wd_valid}, 3'b100);

    // R12 load discards a held to-host byte
    host_pio = 1;
    load(3, 0);
    rd_valid = 1; rd_data = 8'h11;
    @(negedge clk); rd_valid = 0; #1;
    check(!data_en_n, "R12", data_en_n, 0);
    cnt_load = 1; cnt_dir = 0; cnt_value = CW'(2);
    host_rd = 1; host_cmd = 0; #1;
    check(eot_n && !wait_drq, "R12", {eot_n, wait_drq}, 2'b10);
    @(negedge clk); cnt_load = 0; host_rd = 0; #1;
    check(data_en_n && rd_ready, "R12", {data_en_n, rd_ready}, 2'b11);
    rd_valid = 1; rd_data = 8'h22;
    @(negedge clk); rd_valid = 0; host_rd = 1; #1;
    check(host_rdata == 16'h0022 && eot_n, "R12", host_rdata, 16'h0022);
    @(negedge clk); host_rd = 0; #1;
    check(data_en_n, "R6", data_en_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule